// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits in the decode stage of an in-order pipeline. Behind decode are an integer path, a pipelined floating-point adder, a pipelined multiplier and a divider that is not pipelined. Each cycle it looks at the decoded instruction: its unit class, its destination register, its two source registers and a valid bit. It then either lets the instruction issue or holds it in decode.

Every instruction that issues passes through its unit's execute stages, then one memory stage, then write-back. The block keeps a shadow copy of every execute stage of the adder and multiplier, an occupancy counter for the divider, and a flag for a load that is still in its execute stage. With these it detects three kinds of hazard before issue:

- read-after-write (RAW): a source register is still being computed;
- write-after-write (WAW): the destination matches an unfinished floating-point operation;
- structural: the divider is busy.

A shift register records which future cycles already own the single register-file write port, so a write-back collision is also caught before issue.

Top module: `ilk_issue_check`

## Requirements
- R1: When id_valid is high, exactly one of issue and stall is high; when id_valid is low, both are low. The id_unit codes are 0 for integer, 1 for FP add, 2 for multiply and 3 for divide. id_is_load marks an integer-class load.
- R2: Synchronous active-low reset clears all tracking state. The first valid instruction after reset issues at once, whatever was in flight before the reset.
- R3: A reader of an integer ALU result may issue in the cycle right after the producer, with no stall.
- R4: A reader of a load result that is presented right after the load stalls for exactly 1 cycle.
- R5: A reader of an FP add result that is presented right after the add stalls for 3 cycles. The adder has 4 execute stages.
- R6: A reader of a multiply result stalls for 6 cycles. The multiplier has 7 execute stages.
- R7: A reader of a divide result stalls for 24 cycles. The divider occupies 25 cycles, and a second divide cannot issue earlier than 25 cycles after the first.
- R8: An instruction whose destination matches an adder, multiplier or divider operation still in any of its execute stages stalls until that operation leaves execute. Integer and load producers do not cause WAW stalls.
- R9: The write-back cycle is the issue cycle plus the execute depth plus 2. The execute depths are 1 for integer, 4 for add, 7 for multiply and 25 for divide. If this cycle is already reserved, the instruction stalls for one cycle and is checked again.
- R10: An instruction with id_valid low never stalls. It sets no reservation, no tracker and no divider occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_unit | input | 2 | Unit class: 0 integer, 1 FP add, 2 multiply, 3 divide |
| id_is_load | input | 1 | Integer-class instruction is a load |
| id_dst | input | REG_W | Destination register |
| id_src_a | input | REG_W | First source register |
| id_src_b | input | REG_W | Second source register |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode |

## Verification
The bench first issues one producer of each of five kinds: integer ALU, load, add, multiply and divide. It then presents a consumer of each kind, 1 to 4 cycles later, in one of four relations to the producer:

- unrelated registers;
- RAW through the first source;
- RAW through the second source;
- WAW on the destination.

For each case the bench counts the stall cycles and compares them with a count derived from the latencies and the write-port cycle arithmetic. The RAW and WAW cases show the off-by-one gap between the reader window and the writer window. The delayed start gaps place a consumer exactly on an occupied write-back slot. A divide after a divide separates the structural hold from the data hazards. Further runs check a reset in the middle of a divide and bubbles that carry hazardous fields.

// File: rtl/ilk_pkg.sv
// Shared types for the issue interlock.
package ilk_pkg;

    // Unit class codes carried by the decode slot.
    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_FDIV = 2'd3
    } unit_e;

endpackage

// File: rtl/ilk_stage_pipe.sv
// Shadow of a fully pipelined execute unit: one valid/destination pair per
// stage, advancing every cycle. Assumes one push at most per cycle.
module ilk_stage_pipe #(
    parameter int DEPTH = 4,
    parameter int REG_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [REG_W-1:0]            push_dst,
    output logic [DEPTH-1:0]            stg_vld,
    output logic [DEPTH-1:0][REG_W-1:0] stg_dst
);

    // Stage 0 takes the newly issued operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld[0] <= 1'b0;
            stg_dst[0] <= '0;
        end else begin
            stg_vld[0] <= push;
            stg_dst[0] <= push_dst;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        // Each later stage copies its predecessor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_vld[i] <= 1'b0;
                stg_dst[i] <= '0;
            end else begin
                stg_vld[i] <= stg_vld[i-1];
                stg_dst[i] <= stg_dst[i-1];
            end
        end
    end

endmodule

// File: rtl/ilk_div_track.sv
// Occupancy tracker for the non-pipelined divider. The counter holds the
// cycles left in execute. "early" is high while the operation is in any
// stage but its last, which both blocks readers and blocks a new divide.
module ilk_div_track #(
    parameter int DEPTH = 25,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [REG_W-1:0] push_dst,
    output logic             occ,
    output logic             early,
    output logic [REG_W-1:0] dst
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] left_q;

    // Load the full depth on issue, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            dst    <= '0;
        end else if (push) begin
            left_q <= CNT_W'(DEPTH);
            dst    <= push_dst;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign occ   = (left_q != '0);
    assign early = (left_q > CNT_W'(1));

    AST_DIV_NOT_REENTERED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !early); // R7

endmodule

// File: rtl/ilk_wport_resv.sv
// Write-port reservation shift register. Bit j set means the port is taken
// j+1 cycles from now. The register shifts one place every clock. Assumes the
// probe offset is at least 2 and at most SPAN.
module ilk_wport_resv #(
    parameter int SPAN = 27
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SPAN+1)-1:0] probe_off,
    input  logic                      book_en,
    output logic                      probe_hit
);

    localparam int OFF_W = $clog2(SPAN + 1);
    localparam int IDX_W = $clog2(SPAN);

    logic [SPAN-1:0]  resv_q;
    logic [SPAN-1:0]  book_vec;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] book_idx;

    assign hit_idx   = IDX_W'(probe_off - OFF_W'(1));
    assign book_idx  = IDX_W'(probe_off - OFF_W'(2));
    assign probe_hit = resv_q[hit_idx];

    // Place the booking one slot nearer, because the register shifts as it is written.
    always_comb begin
        book_vec           = '0;
        book_vec[book_idx] = book_en;
    end

    // Advance time by one cycle and merge any new booking.
    always_ff @(posedge clk) begin
        if (!rst_n) resv_q <= '0;
        else        resv_q <= (resv_q >> 1) | book_vec;
    end

    AST_WPORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        book_en |-> !probe_hit); // R9

endmodule

// File: rtl/ilk_issue_check.sv
// Decode-stage issue interlock for an in-order pipeline with integer, FP add,
// multiply and divide units. Assumes every instruction writes one register,
// that both source fields are always read, and that results are forwarded
// once the producer leaves its last execute stage (loads: after memory).
module ilk_issue_check
    import ilk_pkg::*;
#(
    parameter int REG_W     = 5,
    parameter int ADD_DEPTH = 4,
    parameter int MUL_DEPTH = 7,
    parameter int DIV_DEPTH = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [1:0]       id_unit,
    input  logic             id_is_load,
    input  logic [REG_W-1:0] id_dst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    output logic             issue,
    output logic             stall
);

    localparam int INT_DEPTH = 1;
    localparam int TAIL      = 2;   // memory stage plus write-back
    localparam int OFF_INT   = INT_DEPTH + TAIL;
    localparam int OFF_ADD   = ADD_DEPTH + TAIL;
    localparam int OFF_MUL   = MUL_DEPTH + TAIL;
    localparam int OFF_DIV   = DIV_DEPTH + TAIL;
    localparam int SPAN_AM   = (OFF_ADD > OFF_MUL) ? OFF_ADD : OFF_MUL;
    localparam int SPAN_AMD  = (SPAN_AM > OFF_DIV) ? SPAN_AM : OFF_DIV;
    localparam int SPAN      = (SPAN_AMD > OFF_INT) ? SPAN_AMD : OFF_INT;
    localparam int OFF_W     = $clog2(SPAN + 1);
    localparam int SC_W      = $clog2(DIV_DEPTH + 1);

    unit_e unit;
    assign unit = unit_e'(id_unit);

    logic                            push_add, push_mul, push_div;
    logic [ADD_DEPTH-1:0]            add_vld;
    logic [ADD_DEPTH-1:0][REG_W-1:0] add_dst;
    logic [MUL_DEPTH-1:0]            mul_vld;
    logic [MUL_DEPTH-1:0][REG_W-1:0] mul_dst;
    logic                            div_occ, div_early;
    logic [REG_W-1:0]                div_dst;
    logic                            ld_vld_q;
    logic [REG_W-1:0]                ld_dst_q;
    logic [OFF_W-1:0]                wb_off;
    logic                            port_hit;
    logic [ADD_DEPTH-1:0]            add_rd, add_wr;
    logic [MUL_DEPTH-1:0]            mul_rd, mul_wr;
    logic                            ld_rd, div_rd, div_wr, div_struct;
    logic                            hazard;

    assign push_add = issue && (unit == UNIT_FADD);
    assign push_mul = issue && (unit == UNIT_FMUL);
    assign push_div = issue && (unit == UNIT_FDIV);

    ilk_stage_pipe #(.DEPTH(ADD_DEPTH), .REG_W(REG_W)) u_add_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_add),
        .push_dst (id_dst),
        .stg_vld  (add_vld),
        .stg_dst  (add_dst)
    );

    ilk_stage_pipe #(.DEPTH(MUL_DEPTH), .REG_W(REG_W)) u_mul_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_mul),
        .push_dst (id_dst),
        .stg_vld  (mul_vld),
        .stg_dst  (mul_dst)
    );

    ilk_div_track #(.DEPTH(DIV_DEPTH), .REG_W(REG_W)) u_div_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_div),
        .push_dst (id_dst),
        .occ      (div_occ),
        .early    (div_early),
        .dst      (div_dst)
    );

    // Remember a load sitting in its execute stage (its data is one cycle late).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_vld_q <= 1'b0;
            ld_dst_q <= '0;
        end else begin
            ld_vld_q <= issue && (unit == UNIT_INT) && id_is_load;
            ld_dst_q <= id_dst;
        end
    end

    // Cycles from issue to write-back for the incoming unit class.
    always_comb begin
        case (unit)
            UNIT_FADD: wb_off = OFF_W'(OFF_ADD);
            UNIT_FMUL: wb_off = OFF_W'(OFF_MUL);
            UNIT_FDIV: wb_off = OFF_W'(OFF_DIV);
            default:   wb_off = OFF_W'(OFF_INT);
        endcase
    end

    ilk_wport_resv #(.SPAN(SPAN)) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .probe_off (wb_off),
        .book_en   (issue),
        .probe_hit (port_hit)
    );

    // Adder stages: readers are blocked in all but the last stage, writers in every stage.
    for (genvar i = 0; i < ADD_DEPTH; i++) begin : g_add_cmp
        if (i < ADD_DEPTH - 1) begin : g_rd
            assign add_rd[i] = add_vld[i] &&
                               (add_dst[i] == id_src_a || add_dst[i] == id_src_b);
        end else begin : g_last
            assign add_rd[i] = 1'b0;
        end
        assign add_wr[i] = add_vld[i] && (add_dst[i] == id_dst);
    end

    // Multiplier stages: same windows as the adder.
    for (genvar i = 0; i < MUL_DEPTH; i++) begin : g_mul_cmp
        if (i < MUL_DEPTH - 1) begin : g_rd
            assign mul_rd[i] = mul_vld[i] &&
                               (mul_dst[i] == id_src_a || mul_dst[i] == id_src_b);
        end else begin : g_last
            assign mul_rd[i] = 1'b0;
        end
        assign mul_wr[i] = mul_vld[i] && (mul_dst[i] == id_dst);
    end

    assign ld_rd      = ld_vld_q && (ld_dst_q == id_src_a || ld_dst_q == id_src_b);
    assign div_rd     = div_early && (div_dst == id_src_a || div_dst == id_src_b);
    assign div_wr     = div_occ && (div_dst == id_dst);
    assign div_struct = div_early && (unit == UNIT_FDIV);

    // Any hazard class holds the instruction in decode.
    always_comb begin
        hazard = (|add_rd) | (|mul_rd) | ld_rd | div_rd |
                 (|add_wr) | (|mul_wr) | div_wr |
                 div_struct | port_hit;
    end

    assign issue = id_valid && !hazard;
    assign stall = id_valid && hazard;

    // Checker state: first cycle after reset, and cycles since the last divide issue.
    logic            fresh_q;
    logic [SC_W-1:0] div_gap_q;

    // Track the checker state used by the assertions below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q   <= 1'b1;
            div_gap_q <= SC_W'(DIV_DEPTH);
        end else begin
            fresh_q <= 1'b0;
            if (push_div)                            div_gap_q <= SC_W'(1);
            else if (div_gap_q < SC_W'(DIV_DEPTH))   div_gap_q <= div_gap_q + 1'b1;
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (issue != stall)); // R1
    AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!issue && !stall)); // R10
    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh_q && id_valid) |-> issue); // R2
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && unit == UNIT_FDIV) |-> (div_gap_q >= SC_W'(DIV_DEPTH))); // R7

endmodule

// File: tb/ilk_issue_check_tb_top.sv
`timescale 1ns/1ps
module ilk_issue_check_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [1:0] id_unit = 2'd0;
    logic       id_is_load = 1'b0;
    logic [4:0] id_dst = '0;
    logic [4:0] id_src_a = '0;
    logic [4:0] id_src_b = '0;
    logic       issue, stall;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #2.5 clk = ~clk;

    ilk_issue_check dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_valid   (id_valid),
        .id_unit    (id_unit),
        .id_is_load (id_is_load),
        .id_dst     (id_dst),
        .id_src_a   (id_src_a),
        .id_src_b   (id_src_b),
        .issue      (issue),
        .stall      (stall)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog actual=%0d cycles expected<=150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Class index: 0 ALU, 1 load, 2 add, 3 mul, 4 div.
    function automatic int depth_of(input int k);
        case (k)
            2: return 4;
            3: return 7;
            4: return 25;
            default: return 1;
        endcase
    endfunction

    function automatic int lat_of(input int k);
        case (k)
            1: return 1;
            2: return 3;
            3: return 6;
            4: return 24;
            default: return 0;
        endcase
    endfunction

    task automatic drive(input logic v, input int k, input logic [4:0] d,
                         input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        id_valid   = v;
        id_unit    = (k <= 1) ? 2'd0 : 2'(k - 1);
        id_is_load = (k == 1);
        id_dst     = d;
        id_src_a   = a;
        id_src_b   = b;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        id_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // rel: 0 unrelated, 1 RAW via src_a, 2 RAW via src_b, 3 WAW.
    task automatic run_pair(input int p, input int c, input int rel, input int g0);
        int stalls = 0;
        int g;
        bit excl_ok = 1'b1;
        logic [4:0] cd, ca, cb;
        string tag;
        do_reset();
        drive(1'b1, p, 5'd5, 5'd1, 5'd2);
        if (!issue) check(1'b0, "R2", int'(issue), 1);
        for (int k = 1; k < g0; k++) drive(1'b0, 0, 5'd5, 5'd5, 5'd5);
        cd = (rel == 3) ? 5'd5 : 5'd10;
        ca = (rel == 1) ? 5'd5 : 5'd11;
        cb = (rel == 2) ? 5'd5 : 5'd12;
        for (int k = 0; k < 60; k++) begin
            drive(1'b1, c, cd, ca, cb);
            if (issue == stall) excl_ok = 1'b0;
            if (issue) break;
            stalls++;
        end
        drive(1'b0, 0, 5'd0, 5'd0, 5'd0);
        // Expected: first gap meeting every hazard rule.
        g = g0;
        forever begin
            bit ok = 1'b1;
            if ((rel == 1 || rel == 2) && g < lat_of(p) + 1) ok = 1'b0;
            if (rel == 3 && p >= 2 && g < depth_of(p) + 1) ok = 1'b0;
            if (p == 4 && c == 4 && g < 25) ok = 1'b0;
            if (g + depth_of(c) == depth_of(p)) ok = 1'b0;
            if (ok) break;
            g++;
        end
        if (rel == 1 || rel == 2) begin
            case (p)
                0: tag = "R3";
                1: tag = "R4";
                2: tag = "R5";
                3: tag = "R6";
                default: tag = "R7";
            endcase
        end else if (rel == 3) tag = "R8";
        else if (p == 4 && c == 4) tag = "R7";
        else tag = "R9";
        check(excl_ok, "R1", int'(excl_ok), 1);
        check(stalls == g - g0, tag, stalls, g - g0);
    endtask

    initial begin
        // R2: reset state and immediate issue
        do_reset();
        drive(1'b0, 4, 5'd3, 5'd3, 5'd3);
        check(issue == 1'b0 && stall == 1'b0, "R10", int'({issue, stall}), 0);
        drive(1'b1, 4, 5'd3, 5'd1, 5'd2);
        check(issue == 1'b1, "R2", int'(issue), 1);
        drive(1'b1, 0, 5'd4, 5'd3, 5'd0);
        check(stall == 1'b1, "R7", int'(stall), 1);
        // R2: reset while a divide is in flight frees everything
        do_reset();
        drive(1'b1, 4, 5'd6, 5'd3, 5'd3);
        check(issue == 1'b1, "R2", int'(issue), 1);

        // R10: bubbles with hazardous fields leave no trace
        do_reset();
        drive(1'b0, 4, 5'd7, 5'd1, 5'd2);
        check(stall == 1'b0, "R10", int'(stall), 0);
        drive(1'b1, 4, 5'd8, 5'd7, 5'd7);
        check(issue == 1'b1, "R10", int'(issue), 1);
        do_reset();
        drive(1'b0, 3, 5'd9, 5'd1, 5'd2);
        drive(1'b0, 0, 5'd0, 5'd0, 5'd0);
        drive(1'b0, 0, 5'd0, 5'd0, 5'd0);
        drive(1'b1, 2, 5'd9, 5'd9, 5'd1);
        check(issue == 1'b1, "R10", int'(issue), 1);

        // Sweep producer x consumer x relation x start gap.
        for (int p = 0; p < 5; p++)
            for (int c = 0; c < 5; c++)
                for (int rel = 0; rel < 4; rel++)
                    for (int g0 = 1; g0 <= 4; g0++)
                        run_pair(p, c, rel, g0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule